// File: doc/BRIEF.md
# Pixel Gain Color Steering Sequencer

This block sits in the pixel clock domain of an image sensor front end. On every pixel clock it emits a 2-bit color index, which picks one of four per-color gain words. It also drives out the gain word that the index selects. The index walks through a short repeating pattern that matches the sensor's color filter layout. Seven layouts are supported: three two-color mosaic variants, two three-color variants and two four-color variants. A line sync, a frame sync and a field flag restart or swap the pattern, and each layout applies its own rules to their edges.

A small write port loads the layout code and the four gain words. The sync inputs are sampled on the pixel clock. An edge is found by comparing each input with its value one clock earlier. A restart shows at the index on the first clock after the edge. The gain word is registered, so it lags the index by one clock.

Top module: `color_gain_steer`

## Requirements
- R1: While reset is asserted, and until the first write, `color_idx` is 0 and `gain_word` is 0. The layout code resets to 0.
- R2: A write with `cfg_addr` 0 to 3 loads gain word 0 to 3. A write with `cfg_addr` 4 loads the layout code from `cfg_wdata[2:0]`. `gain_word` equals the gain word addressed by `color_idx` one clock earlier, using the gain words as they stood before that clock edge.
- R3: Layout 0, two-line mosaic. A falling frame sync selects line A (0,1,0,1...). The first falling line sync after it restarts line A. Each later falling line sync swaps between line A and line B (2,3,2,3...). The field flag has no effect.
- R4: Layout 1, field mosaic. A falling field flag restarts line 0,1. A rising field flag restarts line 2,3. A falling line sync restarts at 0 while the field flag is low and at 2 while it is high. The frame sync has no effect.
- R5: Layout 2, shifted mosaic. The rules are those of layout 0, with line B being 1,2,1,2....
- R6: Layout 3. Every line runs 0,1,2,0,1,2... A falling frame sync or a falling line sync restarts it at 0, and the index is never 3.
- R7: Layout 4. The rules are those of layout 0, with line A being 0,1,2 and line B being 2,1,0, each repeating.
- R8: Layout 5. Every line runs 0,1,2,3,... A falling frame sync or a falling line sync restarts it at 0.
- R9: Layout 6. The rules are those of layout 0, with line A being 0,1,2,3 and line B being 2,3,0,1, each repeating.
- R10: Layout code 7 behaves exactly as layout 0.
- R11: When the frame sync and the line sync fall in the same clock, the frame rule applies. The next index is at the start of line A, and the next falling line sync keeps line A.
- R12: Only a change from high to low (or from low to high, where a layout uses rising edges) triggers a restart, and the restart shows on the next clock. A sync input held low does not restart the pattern again, and the position then advances by one each clock. If a layout change leaves the position beyond the new pattern length, the position wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_sync | input | 1 | Line sync, active on its falling edge |
| frame_sync | input | 1 | Frame sync, active on its falling edge |
| field_flag | input | 1 | Field flag: low is the odd field, high is the even field |
| cfg_we | input | 1 | Write strobe for the configuration registers |
| cfg_addr | input | 3 | Register select: 0 to 3 for the gain words, 4 for the layout code |
| cfg_wdata | input | GAIN_W | Write data |
| color_idx | output | 2 | Current color index |
| gain_word | output | GAIN_W | Gain word for the previous clock's index |

## Verification
The bench goes after the edge rules. A frame sync and a line sync that fall together must favour the frame rule; a design that toggled the line there would start the frame on line B. A line sync held low for several clocks must not restart the pattern more than once; a level-sensitive design would freeze the index at 0. The first line sync after a frame sync must keep line A; if it toggled instead, every frame would open on the wrong color pair. The field mosaic must follow the field flag in both directions and ignore the frame sync. Gain words rewritten in mid-line must show on `gain_word` with exactly one clock of lag.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic [2:0] {
    MODE_MSEP  = 3'd0,
    MODE_MFLD  = 3'd1,
    MODE_MREP  = 3'd2,
    MODE_3C    = 3'd3,
    MODE_3C_II = 3'd4,
    MODE_4C    = 3'd5,
    MODE_4C_II = 3'd6,
    MODE_RSVD  = 3'd7
  } steer_mode_e;

  localparam int unsigned NUM_GAINS = 4;
  localparam int unsigned IDX_W     = 2;

  // The reserved code folds onto layout 0.
  function automatic steer_mode_e mode_norm(steer_mode_e m);
    return (m == MODE_RSVD) ? MODE_MSEP : m;
  endfunction

  // Last position of the pattern for a layout.
  function automatic logic [IDX_W-1:0] last_pos(steer_mode_e m);
    case (m)
      MODE_3C, MODE_3C_II: return 2'd2;
      MODE_4C, MODE_4C_II: return 2'd3;
      default:             return 2'd1;
    endcase
  endfunction

  // Layouts whose line sync swaps the line type.
  function automatic logic swaps_lines(steer_mode_e m);
    return (m == MODE_MSEP) || (m == MODE_MREP) ||
           (m == MODE_3C_II) || (m == MODE_4C_II);
  endfunction

  // Index from line type and position in the line.
  function automatic logic [IDX_W-1:0] steer_index(steer_mode_e m, logic alt,
                                                   logic [IDX_W-1:0] pos);
    logic [IDX_W-1:0] p3;
    p3 = (pos == 2'd3) ? 2'd0 : pos;
    case (m)
      MODE_MREP:  return {1'b0, pos[0]} + {1'b0, alt};
      MODE_3C:    return p3;
      MODE_3C_II: return alt ? (2'd2 - p3) : p3;
      MODE_4C:    return pos;
      MODE_4C_II: return pos + {alt, 1'b0};
      default:    return {alt, pos[0]};
    endcase
  endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_in,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= sig_in[g];
    end

    always_comb begin
      rise[g] = ~prev_q[g] &  sig_in[g];
      fall[g] =  prev_q[g] & ~sig_in[g];
    end
  end

endmodule

// File: rtl/gain_bank.sv
module gain_bank
  import steer_pkg::*;
#(
  parameter int unsigned GAIN_W    = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned MODE_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [GAIN_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  sel_idx,
  output steer_mode_e       mode_q,
  output logic [GAIN_W-1:0] gain_q
);

  logic [GAIN_W-1:0] gain_r [NUM_GAINS];
  logic [GAIN_W-1:0] gain_d;
  logic              mode_we;

  for (genvar g = 0; g < NUM_GAINS; g++) begin : g_gain
    logic ld;
    always_comb ld = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  gain_r[g] <= '0;
      else if (ld) gain_r[g] <= wr_data;
    end
  end

  always_comb begin
    mode_we = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));
    gain_d  = gain_r[sel_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_MSEP;
    else if (mode_we) mode_q <= steer_mode_e'(wr_data[2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain_q <= '0;
    else        gain_q <= gain_d;
  end

  assert_mode_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_q == $past(wr_data[2:0])));

endmodule

// File: rtl/steer_seq.sv
module steer_seq
  import steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  steer_mode_e      mode_raw,
  input  logic             hd_fall,
  input  logic             vd_fall,
  input  logic             fld_rise,
  input  logic             fld_fall,
  input  logic             fld_lvl,
  output logic [IDX_W-1:0] idx
);

  steer_mode_e      mode;
  logic [IDX_W-1:0] pos_q, pos_d, pos_adv;
  logic             alt_q, alt_d;
  logic             keep_q, keep_d;

  always_comb begin
    mode    = mode_norm(mode_raw);
    pos_adv = (pos_q >= last_pos(mode)) ? '0 : pos_q + 2'd1;
    pos_d   = pos_adv;
    alt_d   = alt_q;
    keep_d  = keep_q;
    if (mode == MODE_MFLD) begin
      if (hd_fall || fld_rise || fld_fall) begin
        pos_d = '0;
        alt_d = fld_lvl;
      end
    end else if (vd_fall) begin
      pos_d  = '0;
      alt_d  = 1'b0;
      keep_d = 1'b1;
    end else if (hd_fall) begin
      pos_d  = '0;
      keep_d = 1'b0;
      if (swaps_lines(mode)) alt_d = keep_q ? alt_q : ~alt_q;
      else                   alt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      alt_q  <= 1'b0;
      keep_q <= 1'b1;
    end else begin
      pos_q  <= pos_d;
      alt_q  <= alt_d;
      keep_q <= keep_d;
    end
  end

  always_comb idx = steer_index(mode, alt_q, pos_q);

  assert_line_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hd_fall |=> (pos_q == '0));

  assert_frame_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_fall && mode != MODE_MFLD) |=> (pos_q == '0 && !alt_q && keep_q));

  assert_field_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MFLD && (fld_rise || fld_fall)) |=> (alt_q == $past(fld_rise)));

  assert_three_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_3C || mode == MODE_3C_II) |-> (idx != 2'd3));

endmodule

// File: rtl/color_gain_steer.sv
module color_gain_steer
  import steer_pkg::*;
#(
  parameter int unsigned GAIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_sync,
  input  logic              frame_sync,
  input  logic              field_flag,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [GAIN_W-1:0] cfg_wdata,
  output logic [1:0]        color_idx,
  output logic [GAIN_W-1:0] gain_word
);

  localparam int unsigned NSYNC = 3;

  logic [1:0]       rst_ff;
  logic             rst_s_n;
  logic [NSYNC-1:0] rise, fall;
  steer_mode_e      mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_s_n = rst_ff[1];

  sync_edge_det #(.N(NSYNC)) edge_i (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .sig_in ({field_flag, frame_sync, line_sync}),
    .rise   (rise),
    .fall   (fall)
  );

  steer_seq seq_i (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .mode_raw (mode_q),
    .hd_fall  (fall[0]),
    .vd_fall  (fall[1]),
    .fld_rise (rise[2]),
    .fld_fall (fall[2]),
    .fld_lvl  (field_flag),
    .idx      (color_idx)
  );

  gain_bank #(.GAIN_W(GAIN_W), .ADDR_W(3), .MODE_ADDR(4)) bank_i (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .sel_idx (color_idx),
    .mode_q  (mode_q),
    .gain_q  (gain_word)
  );

endmodule

// File: tb/color_gain_steer_tb_top.sv
module color_gain_steer_tb_top;

  localparam int GW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic hs, vs, fd, we;
  logic [2:0] addr;
  logic [GW-1:0] wdata;
  logic [1:0] idx;
  logic [GW-1:0] gout;

  always #2 clk = ~clk;

  color_gain_steer #(.GAIN_W(GW)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_sync(hs), .frame_sync(vs), .field_flag(fd),
    .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
    .color_idx(idx), .gain_word(gout)
  );

  typedef struct {
    int    e_idx;
    int    e_gain;
    bit    c_idx;
    bit    c_gain;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_run = 0, n_fail = 0;
  string tag = "R1";

  // Reference model state
  int m_mode = 0, m_pos = 0;
  bit m_line = 0, m_keep = 1, m_known = 0;
  bit p_hs = 1, p_vs = 1, p_fd = 0;
  int m_gain [4] = '{0, 0, 0, 0};
  bit cur_fd = 0;

  function automatic int eff(int md);
    return (md == 7) ? 0 : md;
  endfunction

  function automatic int plen(int e);
    if (e <= 2) return 2;
    if (e <= 4) return 3;
    return 4;
  endfunction

  function automatic int pat(int md, bit ln, int p);
    int e, t;
    e = eff(md);
    t = (p > 2) ? 0 : p;
    case (e)
      2:       return (ln ? 1 : 0) + p % 2;
      3:       return t;
      4:       return ln ? 2 - t : t;
      5:       return p;
      6:       return (p + (ln ? 2 : 0)) % 4;
      default: return (ln ? 2 : 0) + p % 2;
    endcase
  endfunction

  task automatic check(string t, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic cyc(bit h, bit v, bit f, bit w = 0, int a = 0, int d = 0);
    exp_t it;
    bit hf, vf, ff, fr;
    int e;
    @(negedge clk);
    hs = h; vs = v; fd = f; we = w; addr = 3'(a); wdata = GW'(d);
    hf = p_hs & ~h; vf = p_vs & ~v; ff = p_fd & ~f; fr = ~p_fd & f;
    e = eff(m_mode);
    it.e_gain = m_gain[pat(m_mode, m_line, m_pos)];
    it.c_gain = m_known;
    if (e == 1) begin
      if (hf || ff || fr) begin m_pos = 0; m_line = f; m_known = 1; end
      else m_pos = (m_pos >= plen(e) - 1) ? 0 : m_pos + 1;
    end else if (vf) begin
      m_pos = 0; m_line = 0; m_keep = 1; m_known = 1;
    end else if (hf) begin
      m_pos = 0;
      if (e == 0 || e == 2 || e == 4 || e == 6) m_line = m_keep ? m_line : ~m_line;
      else m_line = 0;
      m_keep = 0;
    end else begin
      m_pos = (m_pos >= plen(e) - 1) ? 0 : m_pos + 1;
    end
    if (w) begin
      if (a < 4) m_gain[a] = d % 256;
      else if (a == 4) m_mode = d % 8;
    end
    p_hs = h; p_vs = v; p_fd = f;
    it.e_idx = pat(m_mode, m_line, m_pos);
    it.c_idx = m_known;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run_line(int n);
    cyc(0, 1, cur_fd);
    for (int i = 1; i < n; i++) cyc(1, 1, cur_fd);
  endtask

  task automatic frame_start();
    cyc(1, 0, cur_fd);
  endtask

  task automatic set_mode(int md);
    cyc(1, 1, cur_fd, 1, 4, md);
  endtask

  // Monitor: compares outputs just after each clock edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      if (it.c_idx) check({it.tag, " color_idx"}, int'(idx), it.e_idx);
      if (it.c_gain) check({it.tag, " gain_word"}, int'(gout), it.e_gain);
    end
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; hs = 1; vs = 1; fd = 0; we = 0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 color_idx in reset", int'(idx), 0);
    check("R1 gain_word in reset", int'(gout), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);

    tag = "R3"; frame_start();
    tag = "R2";
    cyc(1, 1, 0, 1, 0, 8'h11); cyc(1, 1, 0, 1, 1, 8'h22);
    cyc(1, 1, 0, 1, 2, 8'h33); cyc(1, 1, 0, 1, 3, 8'h44);
    tag = "R3"; frame_start();
    repeat (3) run_line(6);
    tag = "R2"; cyc(1, 1, 0, 1, 1, 8'h5A); cyc(1, 1, 0); cyc(1, 1, 0);

    tag = "R4"; set_mode(1);
    cur_fd = 1; cyc(1, 1, 1); run_line(5); run_line(5);
    frame_start(); run_line(4);
    cur_fd = 0; cyc(1, 1, 0); run_line(5); run_line(5);

    tag = "R5"; set_mode(2); frame_start(); repeat (3) run_line(5);
    tag = "R6"; set_mode(3); frame_start(); repeat (2) run_line(7);
    tag = "R7"; set_mode(4); frame_start(); repeat (3) run_line(7);
    tag = "R8"; set_mode(5); frame_start(); repeat (2) run_line(9);
    tag = "R9"; set_mode(6); frame_start(); repeat (3) run_line(9);
    tag = "R10"; set_mode(7); frame_start(); repeat (3) run_line(5);

    tag = "R11"; set_mode(6); frame_start(); run_line(6); run_line(6);
    cyc(0, 0, 0); cyc(1, 1, 0); cyc(1, 1, 0);
    run_line(6); run_line(6);

    tag = "R12"; set_mode(5); frame_start();
    for (int i = 0; i < 7; i++) cyc(0, 1, 0);
    run_line(5);
    set_mode(3); cyc(1, 1, 0); cyc(1, 1, 0); run_line(4);
    tag = "R2"; cyc(1, 1, 0, 1, 0, 8'hC3); cyc(1, 1, 0); cyc(1, 1, 0); cyc(1, 1, 0);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule